// File: doc/BRIEF.md
# Half-Pel Motion Compensation Predictor

This block builds an 8x8 block of 8-bit predicted pixels from reference rows delivered one per cycle by an upstream aligner. Each delivered row carries nine pixels: the eight pixels of the row plus the pixel to their right. The block can form the prediction in four ways. It can copy the pixels, take a horizontal half-pel average, take a vertical half-pel average, or take a diagonal half-pel average over a 2x2 neighbourhood. A one-bit rounding control decides whether ties round up or down.

A run begins with a start pulse that carries a 5-bit configuration code. The block then takes rows until eight prediction rows have been produced. Each prediction row is registered as two 32-bit words, and a done flag marks the eighth row. The vertical and diagonal modes keep state from the row before: the raw pixels for vertical, and the per-pair half sums and xor bits for diagonal. Because of this, every reference row is fed only once, and nine rows give eight outputs. The datapath works on four-pixel lanes. Within a lane the diagonal average is computed from half sums plus a per-byte correction bit, so no intermediate value is wider than a pixel plus one bit.

Top module: `mcp_predictor`

## Requirements
- R1: While reset is high and after it is released, pred_valid, pred_done and busy are low and pred_row is zero.
- R2: A start pulse seen while busy is low latches cfg_code and raises busy on the next cycle. The code is laid out as {type[4:3], rnd[2], offset[1:0]}, with type 0 = copy, 1 = horizontal, 2 = vertical and 3 = diagonal. The offset bits have no effect on the output.
- R3: In copy mode, output pixel i equals input pixel i for i = 0..7, whatever the rounding bit. Eight input rows give eight output rows.
- R4: In horizontal mode, output pixel i = (p[i] + p[i+1] + 1 - rnd) >> 1, where p is the current input row and p[8] is its ninth pixel.
- R5: In vertical mode, the first row after start produces no output. Every later row gives (prev[i] + cur[i] + 1 - rnd) >> 1, so nine rows give eight outputs.
- R6: In diagonal mode, the first row produces no output. Every later row gives (prev[i] + prev[i+1] + cur[i] + cur[i+1] + 2 - rnd) >> 2.
- R7: When all inputs are 255, every mode and rounding setting gives 255 in every pixel, so no lane wraps.
- R8: A row that produces output appears on pred_row, with pred_valid high, in the cycle after it is presented. pred_row holds its value until the next output. Cycles with row_valid low produce no output and do not advance the row count.
- R9: pred_done is high together with the eighth output row of a run and at no other time. In that same cycle busy is low.
- R10: row_valid while busy is low produces no output and does not change the result of the next run.
- R11: A start pulse while busy is high is ignored, and the run continues in its original mode.
- R12: Input pixel i sits at row_pix[8i+7:8i] and output pixel i at pred_row[8i+7:8i]. The low 32-bit word therefore holds pixels 0..3 and the high word holds pixels 4..7.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a run when idle |
| cfg_code | input | 5 | {type, rnd, offset} configuration |
| row_valid | input | 1 | row_pix holds a reference row this cycle |
| row_pix | input | 72 | Nine reference pixels, pixel i at bits 8i+7:8i |
| busy | output | 1 | A run is in progress |
| pred_valid | output | 1 | pred_row holds a new prediction row |
| pred_row | output | 64 | Eight predicted pixels (two 32-bit words) |
| pred_done | output | 1 | Marks the eighth prediction row |

## Verification
The bench uses uniform random rows in each mode with both rounding settings. These runs catch a wrong neighbour, wrong pixel packing or a missing priming row. Checkerboards of 0 and 1 make the sums land exactly on a rounding tie. In diagonal mode the pair sums are 2, so rounding gives 1 or 0, and this separates the two correction rules from each other. Rows of 255 expose any lane that wraps. Extra runs insert idle cycles in the middle of a block, feed rows while idle, and pulse start during a run, to show that the row count and the latched mode stay intact.

// File: rtl/mcp_pkg.sv
package mcp_pkg;
  typedef enum logic [1:0] {
    MODE_COPY = 2'd0,
    MODE_HORZ = 2'd1,
    MODE_VERT = 2'd2,
    MODE_DIAG = 2'd3
  } mode_e;

  localparam int CFG_W    = 5;
  localparam int OFFSET_W = 2;
  localparam int RND_BIT  = 2;
  localparam int MODE_LSB = 3;

  function automatic logic needs_prime(input mode_e m);
    return (m == MODE_VERT) || (m == MODE_DIAG);
  endfunction
endpackage

// File: rtl/mcp_avg2_lane.sv
module mcp_avg2_lane #(
  parameter int PIX_W    = 8,
  parameter int LANE_PIX = 4
) (
  input  logic [PIX_W*LANE_PIX-1:0] a,
  input  logic [PIX_W*LANE_PIX-1:0] b,
  input  logic                      rnd,
  output logic [PIX_W*LANE_PIX-1:0] y
);
  localparam int SUM_W = PIX_W + 1;

  for (genvar k = 0; k < LANE_PIX; k++) begin : g_pix
    logic [SUM_W-1:0] sum;
    always_comb begin
      sum = {1'b0, a[k*PIX_W +: PIX_W]} + {1'b0, b[k*PIX_W +: PIX_W]}
            + {{(SUM_W-1){1'b0}}, ~rnd};
      y[k*PIX_W +: PIX_W] = sum[SUM_W-1:1];
    end
  end
endmodule

// File: rtl/mcp_pair_lane.sv
module mcp_pair_lane #(
  parameter int PIX_W    = 8,
  parameter int LANE_PIX = 4
) (
  input  logic [PIX_W*LANE_PIX-1:0] a,
  input  logic [PIX_W*LANE_PIX-1:0] b,
  output logic [PIX_W*LANE_PIX-1:0] half,
  output logic [LANE_PIX-1:0]       odd
);
  localparam int SUM_W = PIX_W + 1;

  for (genvar k = 0; k < LANE_PIX; k++) begin : g_pix
    logic [SUM_W-1:0] sum;
    always_comb begin
      sum = {1'b0, a[k*PIX_W +: PIX_W]} + {1'b0, b[k*PIX_W +: PIX_W]};
      half[k*PIX_W +: PIX_W] = sum[SUM_W-1:1];
      odd[k] = a[k*PIX_W] ^ b[k*PIX_W];
    end
  end
endmodule

// File: rtl/mcp_avg4_lane.sv
module mcp_avg4_lane #(
  parameter int PIX_W    = 8,
  parameter int LANE_PIX = 4
) (
  input  logic [PIX_W*LANE_PIX-1:0] s0,
  input  logic [LANE_PIX-1:0]       l0,
  input  logic [PIX_W*LANE_PIX-1:0] s1,
  input  logic [LANE_PIX-1:0]       l1,
  input  logic                      rnd,
  output logic [PIX_W*LANE_PIX-1:0] y
);
  localparam int SUM_W = PIX_W + 1;

  for (genvar k = 0; k < LANE_PIX; k++) begin : g_pix
    logic [SUM_W-1:0] sum;
    logic             par;
    logic             fix;
    always_comb begin
      sum = {1'b0, s0[k*PIX_W +: PIX_W]} + {1'b0, s1[k*PIX_W +: PIX_W]};
      par = s0[k*PIX_W] ^ s1[k*PIX_W];
      // correction bit: round-up rule needs either odd half-sum pair or both odd pairs
      fix = rnd ? (par & (l0[k] | l1[k])) : (par | (l0[k] & l1[k]));
      y[k*PIX_W +: PIX_W] = sum[SUM_W-1:1] + {{(PIX_W-1){1'b0}}, fix};
    end
  end
endmodule

// File: rtl/mcp_ctrl.sv
module mcp_ctrl
  import mcp_pkg::*;
#(
  parameter int ROWS = 8
) (
  input  logic  clk,
  input  logic  rst,
  input  logic  start,
  input  mode_e cfg_mode,
  input  logic  cfg_rnd,
  input  logic  row_valid,
  output logic  busy,
  output mode_e mode_q,
  output logic  rnd_q,
  output logic  accept,
  output logic  emit,
  output logic  last
);
  localparam int CNT_W = (ROWS > 1) ? $clog2(ROWS) : 1;
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(ROWS - 1);

  logic             prime_q;
  logic [CNT_W-1:0] cnt_q;

  assign accept = busy & row_valid;
  assign emit   = accept & ~prime_q;
  assign last   = emit & (cnt_q == CNT_LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      busy    <= 1'b0;
      mode_q  <= MODE_COPY;
      rnd_q   <= 1'b0;
      prime_q <= 1'b0;
      cnt_q   <= '0;
    end else if (!busy) begin
      if (start) begin
        busy    <= 1'b1;
        mode_q  <= cfg_mode;
        rnd_q   <= cfg_rnd;
        prime_q <= needs_prime(cfg_mode);
        cnt_q   <= '0;
      end
    end else if (row_valid) begin
      if (prime_q) begin
        prime_q <= 1'b0;
      end else if (cnt_q == CNT_LAST) begin
        busy <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end
endmodule

// File: rtl/mcp_predictor.sv
module mcp_predictor
  import mcp_pkg::*;
#(
  parameter int PIX_W    = 8,
  parameter int ROW_PIX  = 8,
  parameter int ROWS     = 8,
  parameter int LANE_PIX = 4
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       start,
  input  logic [CFG_W-1:0]           cfg_code,
  input  logic                       row_valid,
  input  logic [(ROW_PIX+1)*PIX_W-1:0] row_pix,
  output logic                       busy,
  output logic                       pred_valid,
  output logic [ROW_PIX*PIX_W-1:0]   pred_row,
  output logic                       pred_done
);
  localparam int ROW_W  = ROW_PIX * PIX_W;
  localparam int IN_W   = ROW_W + PIX_W;
  localparam int LANE_W = LANE_PIX * PIX_W;
  localparam int LANES  = ROW_PIX / LANE_PIX;

  mode_e cfg_mode;
  logic  cfg_rnd;
  mode_e mode_q;
  logic  rnd_q;
  logic  accept;
  logic  emit;
  logic  last;
  logic  unused_offset;

  assign cfg_mode      = mode_e'(cfg_code[MODE_LSB +: 2]);
  assign cfg_rnd       = cfg_code[RND_BIT];
  assign unused_offset = ^cfg_code[OFFSET_W-1:0];

  mcp_ctrl #(.ROWS(ROWS)) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .start    (start),
    .cfg_mode (cfg_mode),
    .cfg_rnd  (cfg_rnd),
    .row_valid(row_valid),
    .busy     (busy),
    .mode_q   (mode_q),
    .rnd_q    (rnd_q),
    .accept   (accept),
    .emit     (emit),
    .last     (last)
  );

  logic [ROW_W-1:0]   cur_flat;
  logic [ROW_W-1:0]   shf_flat;
  logic [ROW_W-1:0]   prev_pix;
  logic [ROW_W-1:0]   prev_hs;
  logic [ROW_PIX-1:0] prev_hl;
  logic [ROW_W-1:0]   hs_cur;
  logic [ROW_PIX-1:0] hl_cur;
  logic [ROW_W-1:0]   horz_row;
  logic [ROW_W-1:0]   vert_row;
  logic [ROW_W-1:0]   diag_row;
  logic [ROW_W-1:0]   next_row;

  assign cur_flat = row_pix[ROW_W-1:0];
  assign shf_flat = row_pix[IN_W-1:PIX_W];

  for (genvar L = 0; L < LANES; L++) begin : g_lane
    mcp_avg2_lane #(.PIX_W(PIX_W), .LANE_PIX(LANE_PIX)) u_horz (
      .a  (cur_flat[L*LANE_W +: LANE_W]),
      .b  (shf_flat[L*LANE_W +: LANE_W]),
      .rnd(rnd_q),
      .y  (horz_row[L*LANE_W +: LANE_W])
    );
    mcp_avg2_lane #(.PIX_W(PIX_W), .LANE_PIX(LANE_PIX)) u_vert (
      .a  (prev_pix[L*LANE_W +: LANE_W]),
      .b  (cur_flat[L*LANE_W +: LANE_W]),
      .rnd(rnd_q),
      .y  (vert_row[L*LANE_W +: LANE_W])
    );
    mcp_pair_lane #(.PIX_W(PIX_W), .LANE_PIX(LANE_PIX)) u_pair (
      .a   (cur_flat[L*LANE_W +: LANE_W]),
      .b   (shf_flat[L*LANE_W +: LANE_W]),
      .half(hs_cur[L*LANE_W +: LANE_W]),
      .odd (hl_cur[L*LANE_PIX +: LANE_PIX])
    );
    mcp_avg4_lane #(.PIX_W(PIX_W), .LANE_PIX(LANE_PIX)) u_diag (
      .s0 (prev_hs[L*LANE_W +: LANE_W]),
      .l0 (prev_hl[L*LANE_PIX +: LANE_PIX]),
      .s1 (hs_cur[L*LANE_W +: LANE_W]),
      .l1 (hl_cur[L*LANE_PIX +: LANE_PIX]),
      .rnd(rnd_q),
      .y  (diag_row[L*LANE_W +: LANE_W])
    );
  end

  always_comb begin
    case (mode_q)
      MODE_HORZ: next_row = horz_row;
      MODE_VERT: next_row = vert_row;
      MODE_DIAG: next_row = diag_row;
      default:   next_row = cur_flat;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pred_valid <= 1'b0;
      pred_done  <= 1'b0;
      pred_row   <= '0;
      prev_pix   <= '0;
      prev_hs    <= '0;
      prev_hl    <= '0;
    end else begin
      pred_valid <= emit;
      pred_done  <= last;
      if (emit) pred_row <= next_row;
      if (accept) begin
        prev_pix <= cur_flat;
        prev_hs  <= hs_cur;
        prev_hl  <= hl_cur;
      end
    end
  end
endmodule

// File: rtl/mcp_checker.sv
module mcp_checker #(
  parameter int ROW_W = 64
) (
  input logic             clk,
  input logic             rst,
  input logic             row_valid,
  input logic [ROW_W-1:0] row_low,
  input logic             busy,
  input logic             pred_valid,
  input logic             pred_done,
  input logic [ROW_W-1:0] pred_row,
  input logic [1:0]       mode_q
);
  // R9
  done_with_valid_chk: assert property (@(posedge clk) disable iff (rst)
    pred_done |-> pred_valid);

  // R9
  done_ends_busy_chk: assert property (@(posedge clk) disable iff (rst)
    pred_done |-> !busy);

  // R8
  valid_from_row_chk: assert property (@(posedge clk) disable iff (rst)
    pred_valid |-> $past(row_valid && busy));

  // R10
  idle_no_output_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(busy) |-> !pred_valid);

  // R11
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(mode_q));

  // R3
  copy_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (pred_valid && mode_q == 2'd0) |-> (pred_row == $past(row_low)));
endmodule

bind mcp_predictor mcp_checker #(.ROW_W(ROW_PIX*PIX_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .row_valid (row_valid),
  .row_low   (row_pix[ROW_PIX*PIX_W-1:0]),
  .busy      (busy),
  .pred_valid(pred_valid),
  .pred_done (pred_done),
  .pred_row  (pred_row),
  .mode_q    (mode_q)
);

// File: tb/mcp_predictor_bench.sv
`timescale 1ns/1ps
module mcp_predictor_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [4:0]  cfg_code = '0;
  logic        row_valid = 1'b0;
  logic [71:0] row_pix = '0;
  logic        busy;
  logic        pred_valid;
  logic [63:0] pred_row;
  logic        pred_done;

  int tests = 0;
  int fails = 0;

  always #10 clk = ~clk;

  mcp_predictor u_mcp_predictor (
    .clk(clk), .rst(rst), .start(start), .cfg_code(cfg_code),
    .row_valid(row_valid), .row_pix(row_pix), .busy(busy),
    .pred_valid(pred_valid), .pred_row(pred_row), .pred_done(pred_done)
  );

  function automatic logic [63:0] ref_row(int mode, int rnd, logic [71:0] pr, logic [71:0] cr);
    logic [63:0] r;
    for (int i = 0; i < 8; i++) begin
      int a, b, c, d, v;
      a = int'(cr[i*8 +: 8]); b = int'(cr[(i+1)*8 +: 8]);
      c = int'(pr[i*8 +: 8]); d = int'(pr[(i+1)*8 +: 8]);
      case (mode)
        1: v = (a + b + 1 - rnd) / 2;
        2: v = (c + a + 1 - rnd) / 2;
        3: v = (a + b + c + d + 2 - rnd) / 4;
        default: v = a;
      endcase
      r[i*8 +: 8] = v[7:0];
    end
    return r;
  endfunction

  function automatic logic [71:0] make_row(int pat, int idx);
    logic [71:0] r;
    for (int i = 0; i < 9; i++) begin
      case (pat)
        1: r[i*8 +: 8] = 8'hFF;
        2: r[i*8 +: 8] = 8'((idx + i) & 1);
        default: r[i*8 +: 8] = 8'($urandom_range(0, 255));
      endcase
    end
    return r;
  endfunction

  task automatic fail_msg(string tag, string what, logic [63:0] act, logic [63:0] exp);
    fails++;
    $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
  endtask

  // waits to the next negedge and compares the outputs of the cycle just finished
  task automatic step(bit ev, logic [63:0] er, bit ed, string tag);
    @(negedge clk);
    tests++;
    if (pred_valid !== ev) fail_msg(tag, "pred_valid", 64'(pred_valid), 64'(ev));
    tests++;
    if (pred_done !== ed) fail_msg(tag, "pred_done", 64'(pred_done), 64'(ed));
    if (ev) begin
      tests++;
      if (pred_row !== er) fail_msg(tag, "pred_row", pred_row, er);
    end
  endtask

  task automatic run_block(int mode, int rnd, int offset, int pat, bit gap, bit restart, string tag);
    logic [71:0] rows [9];
    logic [71:0] prev;
    int n, outs;
    for (int j = 0; j < 9; j++) rows[j] = make_row(pat, j);
    n = (mode >= 2) ? 9 : 8;
    outs = 0;
    prev = '0;
    @(negedge clk);
    start = 1'b1;
    cfg_code = {2'(mode), 1'(rnd), 2'(offset)};
    @(negedge clk);
    start = 1'b0;
    tests++;
    if (busy !== 1'b1) fail_msg("R2", "busy after start", 64'(busy), 64'd1);
    for (int j = 0; j < n; j++) begin
      bit ev;
      logic [63:0] er;
      if (gap && j == 3) begin
        row_valid = 1'b0;
        step(1'b0, '0, 1'b0, "R8 gap");
        step(1'b0, '0, 1'b0, "R8 gap");
      end
      row_valid = 1'b1;
      row_pix = rows[j];
      if (restart && j == 4) begin
        start = 1'b1;
        cfg_code = {2'(3 - mode), 1'(1 - rnd), 2'd1};
      end
      ev = !((mode >= 2) && (j == 0));
      er = ref_row(mode, rnd, prev, rows[j]);
      step(ev, er, ev && (outs == 7), tag);
      start = 1'b0;
      if (ev) outs++;
      prev = rows[j];
    end
    row_valid = 1'b0;
    tests++;
    if (busy !== 1'b0) fail_msg("R9", "busy after block", 64'(busy), 64'd0);
    step(1'b0, '0, 1'b0, "R9 after done");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: outputs quiet under reset
    tests++;
    if (pred_valid !== 1'b0 || pred_done !== 1'b0 || busy !== 1'b0 || pred_row !== '0)
      fail_msg("R1", "reset outputs", pred_row, '0);
    rst = 1'b0;
    @(negedge clk);
    tests++;
    if (pred_valid !== 1'b0 || busy !== 1'b0)
      fail_msg("R1", "post-reset flags", 64'({pred_valid, busy}), 64'd0);

    run_block(0, 0, 0, 0, 1'b0, 1'b0, "R3 R12 copy rnd0");
    run_block(0, 1, 3, 0, 1'b0, 1'b0, "R3 R2 copy rnd1 offset3");
    run_block(1, 0, 1, 0, 1'b0, 1'b0, "R4 horz rnd0");
    run_block(1, 1, 2, 0, 1'b0, 1'b0, "R4 horz rnd1");
    run_block(1, 0, 0, 2, 1'b0, 1'b0, "R4 horz tie rnd0");
    run_block(1, 1, 0, 2, 1'b0, 1'b0, "R4 horz tie rnd1");
    run_block(2, 0, 0, 0, 1'b1, 1'b0, "R5 R8 vert rnd0 gap");
    run_block(2, 1, 3, 0, 1'b0, 1'b0, "R5 vert rnd1");
    run_block(3, 0, 2, 0, 1'b0, 1'b0, "R6 diag rnd0");
    run_block(3, 1, 1, 0, 1'b1, 1'b0, "R6 diag rnd1 gap");
    run_block(3, 0, 0, 2, 1'b0, 1'b0, "R6 diag tie rnd0");
    run_block(3, 1, 0, 2, 1'b0, 1'b0, "R6 diag tie rnd1");
    run_block(3, 0, 0, 1, 1'b0, 1'b0, "R7 diag 255 rnd0");
    run_block(3, 1, 0, 1, 1'b0, 1'b0, "R7 diag 255 rnd1");
    run_block(1, 0, 0, 1, 1'b0, 1'b0, "R7 horz 255 rnd0");
    run_block(2, 0, 0, 1, 1'b0, 1'b0, "R7 vert 255 rnd0");
    run_block(3, 0, 0, 0, 1'b0, 1'b1, "R11 diag restart ignored");
    run_block(1, 1, 0, 0, 1'b0, 1'b1, "R11 horz restart ignored");

    // R10: rows while idle give nothing and do not disturb the next run
    begin
      logic [63:0] held;
      held = pred_row;
      for (int k = 0; k < 3; k++) begin
        row_valid = 1'b1;
        row_pix = make_row(0, k);
        step(1'b0, '0, 1'b0, "R10 idle row");
        tests++;
        if (pred_row !== held) fail_msg("R10", "pred_row held", pred_row, held);
      end
      row_valid = 1'b0;
    end
    run_block(2, 0, 0, 0, 1'b0, 1'b0, "R10 R5 vert after idle rows");
    run_block(3, 1, 0, 0, 1'b0, 1'b0, "R10 R6 diag after idle rows");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule